// File: doc/BRIEF.md
# Periodic Interrupt and LCD Frame Timer

This block turns the CPU clock of a small 8-bit system into two timing signals. A periodic interrupt request is a pulse of fixed length that fires once every 4096 clocks. An LCD frame line is a square wave whose level changes once per interrupt period. Both come from a single binary divider that counts CPU clocks. The interrupt is tapped at divider stage 12, which has a period of 4096 clocks. The frame line is tapped one stage higher, at stage 13, so it changes once every 4096 clocks.

The divider does not run freely. The address decoder raises a one-cycle strobe when the CPU reads the interrupt-acknowledge location, and that strobe zeroes the divider. Zeroing the divider also pulls the frame line low and ends any interrupt pulse that is still active. Stage 12 rises when the count reaches its midpoint, so the first interrupt after a clear arrives after half a period. A synchronous reset does the same as an acknowledge. The pulse length models an RC network and is given as a parameter in clock cycles.

Top module: `irqft_top`

## Requirements
- R1: While reset is held, and on the cycle after it is released, `irq` and `lcd_frame` are both low.
- R2: After a clear (reset or an acknowledge strobe sampled at a rising edge), `irq` rises on the 2048th rising edge after the clearing edge.
- R3: With no further clear, each later rise of `irq` follows the previous one by exactly 4096 clocks. This spacing is kept across the wrap of the 13-bit divider.
- R4: An interrupt pulse that no clear cuts short stays high for exactly PULSE_CYCLES clocks (68 by default).
- R5: `lcd_frame` changes level on the 4096th edge after a clear and on every 4096th edge after that. So its level changes exactly once between two consecutive interrupt rises.
- R6: An acknowledge strobe drives `irq` and `lcd_frame` low on the next cycle. This holds even while a pulse is in progress, and the divider timing then restarts from zero.
- R7: A clear takes priority over the divider. While the acknowledge strobe is held high, no interrupt starts and `lcd_frame` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock that feeds the divider |
| rst | input | 1 | Synchronous reset, active high, same effect as an acknowledge |
| ack_rd | input | 1 | One-cycle strobe from a CPU read of the acknowledge address |
| irq | output | 1 | Interrupt request pulse, active high |
| lcd_frame | output | 1 | LCD frame square wave, divider stage above the interrupt tap |

## Verification
The assertions check on every cycle that:
- a clear empties both outputs on the next cycle;
- `irq` rises only on the cycle after the stage-12 carry event;
- a pulse never outlasts PULSE_CYCLES and is never cut short except by a clear;
- `lcd_frame` changes level only when the divider carry reaches stage 13.

The absolute spacings need whole scenarios that run for thousands of cycles. These are the 2048-clock delay to the first interrupt after a clear, the 4096-clock spacing across a divider wrap, and the single frame change per period. The bench covers them, together with an acknowledge in the middle of a pulse and a long held acknowledge. A cycle-accurate reference model in the bench is compared with the outputs on every clock.

// File: rtl/irqft_pkg.sv
package irqft_pkg;

  // Clocks from one rising edge of a divider stage to its next one.
  function automatic int stage_period(input int stage);
    return 1 << stage;
  endfunction

  // Clocks from a clear to the first rising edge of a stage.
  function automatic int stage_first_rise(input int stage);
    return 1 << (stage - 1);
  endfunction

  // Bits needed to hold a count of 0..n.
  function automatic int count_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/irqft_divider.sv
module irqft_divider #(
  parameter int WIDTH     = 13,
  parameter int TAP_STAGE = 12
) (
  input  logic             clk,
  input  logic             clear,
  output logic [WIDTH-1:0] count,
  output logic             tap_rise
);

  // Each stage toggles when every stage below it is high.
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] count_nxt;

  assign carry[0] = 1'b1;

  for (genvar s = 0; s < WIDTH; s++) begin : g_stage
    assign carry[s+1]   = carry[s] & count[s];
    assign count_nxt[s] = carry[s] ? ~count[s] : count[s];
  end

  always_ff @(posedge clk) begin
    if (clear) count <= '0;
    else       count <= count_nxt;
  end

  // The tap stage goes from 0 to 1 on this edge.
  assign tap_rise = carry[TAP_STAGE-1] & ~count[TAP_STAGE-1] & ~clear;

endmodule

// File: rtl/irqft_stretch.sv
module irqft_stretch #(
  parameter int PULSE_CYCLES = 68
) (
  input  logic clk,
  input  logic clear,
  input  logic fire,
  output logic active
);

  import irqft_pkg::*;

  localparam int LW = count_bits(PULSE_CYCLES);
  localparam logic [LW-1:0] LOAD = LW'(PULSE_CYCLES);

  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (clear)             left <= '0;
    else if (fire)         left <= LOAD;
    else if (left != '0)   left <= left - 1'b1;
  end

  assign active = (left != '0);

endmodule

// File: rtl/irqft_top.sv
module irqft_top #(
  parameter int IRQ_STAGE    = 12,
  parameter int PULSE_CYCLES = 68
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_rd,
  output logic irq,
  output logic lcd_frame
);

  import irqft_pkg::*;

  localparam int DIV_W        = IRQ_STAGE + 1;
  localparam int FRAME_BIT    = DIV_W - 1;
  localparam int IRQ_PERIOD   = stage_period(IRQ_STAGE);
  localparam int FIRST_IRQ    = stage_first_rise(IRQ_STAGE);

  // Named internal events, exposed for the bound checker.
  logic             clear;
  logic             tap_rise;
  logic [DIV_W-1:0] div_count;

  assign clear = rst | ack_rd;

  irqft_divider #(
    .WIDTH     (DIV_W),
    .TAP_STAGE (IRQ_STAGE)
  ) u_div (
    .clk      (clk),
    .clear    (clear),
    .count    (div_count),
    .tap_rise (tap_rise)
  );

  irqft_stretch #(
    .PULSE_CYCLES (PULSE_CYCLES)
  ) u_pulse (
    .clk    (clk),
    .clear  (clear),
    .fire   (tap_rise),
    .active (irq)
  );

  assign lcd_frame = div_count[FRAME_BIT];

  initial begin
    if (PULSE_CYCLES < 1 || PULSE_CYCLES >= FIRST_IRQ || IRQ_PERIOD < 4)
      $error("irqft_top: pulse length must lie between 1 and half the period");
  end

endmodule

// File: rtl/irqft_checks.sv
module irqft_checks #(
  parameter int PULSE_CYCLES = 68,
  parameter int DIV_W        = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             clear,
  input logic             tap_rise,
  input logic [DIV_W-1:0] div_count,
  input logic             irq,
  input logic             lcd_frame
);

  // Cycles that irq has been high before the current one.
  int hi_len;

  always_ff @(posedge clk) begin
    if (rst)      hi_len <= 0;
    else if (irq) hi_len <= hi_len + 1;
    else          hi_len <= 0;
  end

  // R1, R6, R7: a clear empties both outputs next cycle.
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clear |=> (!irq && !lcd_frame));

  // R2, R3: a pulse starts only after the tap carry event.
  a_r3_rise_from_tap: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(tap_rise));

  a_r2_tap_starts_pulse: assert property (@(posedge clk) disable iff (rst)
    tap_rise |=> irq);

  // R4: never longer than the pulse length.
  a_r4_no_overlong: assert property (@(posedge clk) disable iff (rst)
    irq |-> (hi_len < PULSE_CYCLES));

  // R4: not cut short without a clear.
  a_r4_no_early_end: assert property (@(posedge clk) disable iff (rst)
    (irq && (hi_len < PULSE_CYCLES - 1) && !clear) |=> irq);

  // R5: frame moves only when the carry reaches the top stage.
  a_r5_frame_on_carry: assert property (@(posedge clk) disable iff (rst)
    (!clear && !(&div_count[DIV_W-2:0])) |=> $stable(lcd_frame));

endmodule

bind irqft_top irqft_checks #(
  .PULSE_CYCLES (PULSE_CYCLES),
  .DIV_W        (DIV_W)
) u_checks (
  .clk       (clk),
  .rst       (rst),
  .clear     (clear),
  .tap_rise  (tap_rise),
  .div_count (div_count),
  .irq       (irq),
  .lcd_frame (lcd_frame)
);

// File: tb/irqft_top_bench.sv
module irqft_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PULSE      = 68;
  localparam int PERIOD     = 4096;
  localparam int HALF       = PERIOD / 2;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ack_rd = 1'b0;
  logic irq, lcd_frame;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqft_top #(.IRQ_STAGE(12), .PULSE_CYCLES(PULSE)) u_irqft_top (
    .clk       (clk),
    .rst       (rst),
    .ack_rd    (ack_rd),
    .irq       (irq),
    .lcd_frame (lcd_frame)
  );

  // Behavioural reference: clocks since the last clear, plus remaining pulse.
  longint since = 0;
  int     m_left = 0;
  bit     m_irq, m_frame;

  always @(posedge clk) begin
    if (rst || ack_rd) begin
      since  = 0;
      m_left = 0;
    end else begin
      since = since + 1;
      if (since % PERIOD == HALF) m_left = PULSE;
      else if (m_left > 0)        m_left = m_left - 1;
    end
    m_irq   = (m_left > 0);
    m_frame = ((since / PERIOD) % 2) == 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Event bookkeeping for the scenario checks.
  int  cyc = 0;
  int  clr_mark = 0;
  int  last_rise = -1;
  int  rise_cyc = 0;
  int  frame_moves = 0;
  bit  prev_irq = 0, prev_frame = 0;
  bit  cut_short = 0;
  bit  first_after_clr = 1;

  task automatic step(input bit r, input bit a);
    @(negedge clk);
    cyc++;
    // compare against the model on every clock
    check(irq == m_irq,         "model irq",   irq,       m_irq);
    check(lcd_frame == m_frame, "model frame", lcd_frame, m_frame);
    if (lcd_frame != prev_frame) frame_moves++;
    if (irq && !prev_irq) begin
      if (first_after_clr)
        check(cyc - clr_mark == HALF, "R2 first delay", cyc - clr_mark, HALF);
      else begin
        check(cyc - last_rise == PERIOD, "R3 spacing", cyc - last_rise, PERIOD);
        check(frame_moves == 1, "R5 one frame change per period", frame_moves, 1);
      end
      first_after_clr = 0;
      last_rise   = cyc;
      rise_cyc    = cyc;
      frame_moves = 0;
      cut_short   = 0;
    end
    if (!irq && prev_irq && !cut_short)
      check(cyc - rise_cyc == PULSE, "R4 width", cyc - rise_cyc, PULSE);
    prev_irq   = irq;
    prev_frame = lcd_frame;
    // drive for the next edge
    rst    = r;
    ack_rd = a;
    if (r || a) begin
      clr_mark        = cyc + 1;
      first_after_clr = 1;
      frame_moves     = 0;
      cut_short       = irq;
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    // R1: outputs low right after reset release
    check(irq == 0,       "R1 irq after reset",   irq,       0);
    check(lcd_frame == 0, "R1 frame after reset", lcd_frame, 0);

    // Free run across a divider wrap (R2, R3, R4, R5)
    for (int i = 0; i < 3 * PERIOD + 500; i++) step(1'b0, 1'b0);
    check(lcd_frame == 1, "R5 frame level after three periods", lcd_frame, 1);

    // Wait for a pulse, acknowledge in its middle (R6)
    while (!irq) step(1'b0, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    check(irq == 0,       "R6 irq after ack mid-pulse",   irq,       0);
    check(lcd_frame == 0, "R6 frame after ack mid-pulse", lcd_frame, 0);
    for (int i = 0; i < PERIOD + 200; i++) step(1'b0, 1'b0);

    // Acknowledge while the frame line is high (R6)
    while (!lcd_frame) step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    check(lcd_frame == 0, "R6 frame forced low", lcd_frame, 0);

    // Held acknowledge past the midpoint (R7)
    begin
      bit seen = 0;
      for (int i = 0; i < HALF + 300; i++) begin
        step(1'b0, 1'b1);
        if (irq || lcd_frame) seen = 1;
      end
      check(seen == 0, "R7 no irq or frame while ack held", seen, 0);
    end
    for (int i = 0; i < PERIOD + 100; i++) step(1'b0, 1'b0);

    // Reset in mid run restarts timing (R1, R2)
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    check(irq == 0 && lcd_frame == 0, "R1 outputs after mid-run reset",
          {irq, lcd_frame}, 0);
    for (int i = 0; i < HALF + 200; i++) step(1'b0, 1'b0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(WATCHDOG * CLK_PERIOD);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule